// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. Each cycle it may receive one instruction, marked by a valid strobe. The instruction carries a full-width register operand and a second operand. The second operand is either another register value or a 16-bit immediate, chosen by a flag. A 3-bit condition code selects the comparison. When the selected relation holds, the block raises a trap request on the next clock edge and latches the instruction word that caused it.

Two operations, equality and inequality, compare whole words. The two ordering tests, at-least and below, each come in a signed and an unsigned form. An immediate is always widened by copying its sign bit, and this holds for the unsigned tests as well. For those tests a negative immediate becomes a very large unsigned bound. The trap request is a single-cycle pulse. Redirecting the fetch stream and flushing the pipeline are left to the consumer of the pulse.

Top module: `trap_cond_unit`

## Requirements
- R1: While reset is asserted and after it is released, `trap_fire` is 0 and `trap_word` is all zeros until the first trap.
- R2: Condition code 0 (equal) traps when the two operands match in every bit, and code 1 (not equal) traps when any bit differs, including only the top bit.
- R3: Code 2 traps when `src_a` is at least the second operand as two's-complement numbers, and code 4 traps when it is below.
- R4: Code 3 traps when `src_a` is at least the second operand as unsigned numbers, and code 5 traps when it is below.
- R5: With `use_imm` high, the 16-bit `imm` is widened by copying its bit 15 into all upper bits before any comparison.
- R6: The sign copying of R5 also applies to codes 3 and 5, so immediate 0xFFFF acts as the all-ones unsigned bound.
- R7: Codes 6 and 7 never raise a trap.
- R8: `trap_fire` is high for exactly the one cycle that follows a valid input whose condition holds, and is low in every other cycle, including cycles after inputs with `in_valid` low.
- R9: When `trap_fire` is high, `trap_word` equals the instruction word of the trapping input. Otherwise `trap_word` keeps its last value.
- R10: With `use_imm` high the value on `src_b` has no effect, and with `use_imm` low the value on `imm` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| cond | input | 3 | Condition code (0 eq, 1 ne, 2 ge signed, 3 ge unsigned, 4 lt signed, 5 lt unsigned) |
| use_imm | input | 1 | Compare against the widened immediate instead of `src_b` |
| src_a | input | XLEN (64) | First register operand |
| src_b | input | XLEN (64) | Second register operand |
| imm | input | IMM_W (16) | Immediate operand |
| insn_word | input | INSN_W (32) | Instruction word to report with a trap |
| trap_fire | output | 1 | Single-cycle trap request |
| trap_word | output | INSN_W (32) | Instruction word of the most recent trap |

## Verification
The only state is the registered pulse and the captured instruction word. A wrong decision or a stale capture therefore shows at the ports exactly one cycle after the input that caused it. The bench compares both outputs against a behavioural model on every clock. Because the model applies every input, any misplaced sign bit, inverted relation or missed hold is visible at once.

// File: rtl/trap_cond_unit.sv
module trap_cond_unit #(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 16,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        cond,
  input  logic              use_imm,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [INSN_W-1:0] insn_word,
  output logic              trap_fire,
  output logic [INSN_W-1:0] trap_word
);

  localparam int EXT_W = XLEN - IMM_W;

  localparam logic [2:0] C_EQ  = 3'd0;
  localparam logic [2:0] C_NE  = 3'd1;
  localparam logic [2:0] C_GE  = 3'd2;
  localparam logic [2:0] C_GEU = 3'd3;
  localparam logic [2:0] C_LT  = 3'd4;
  localparam logic [2:0] C_LTU = 3'd5;

  logic [XLEN-1:0] imm_wide, opnd_b;
  logic            same, lt_s, lt_u, hit;

  assign imm_wide = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign opnd_b   = use_imm ? imm_wide : src_b;

  assign same = (src_a == opnd_b);
  assign lt_s = ($signed(src_a) < $signed(opnd_b));
  assign lt_u = (src_a < opnd_b);

  always_comb begin
    case (cond)
      C_EQ:    hit = same;
      C_NE:    hit = !same;
      C_GE:    hit = !lt_s;
      C_GEU:   hit = !lt_u;
      C_LT:    hit = lt_s;
      C_LTU:   hit = lt_u;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_fire <= 1'b0;
      trap_word <= '0;
    end else begin
      trap_fire <= in_valid && hit;
      if (in_valid && hit)
        trap_word <= insn_word;
    end
  end

  AST_FIRE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |-> $past(in_valid)); // R8
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond[2] && cond[1]) |=> !trap_fire); // R7
  AST_WORD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |-> (trap_word == $past(insn_word))); // R9
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_fire && $past(rst_n)) |-> $stable(trap_word)); // R9
  AST_EQ_REG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == C_EQ && !use_imm && src_a == src_b) |=> trap_fire); // R2
  AST_GEU_IMM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == C_GEU && use_imm && &imm && !(&src_a)) |=> !trap_fire); // R6

endmodule

// File: tb/trap_cond_unit_test.sv
module trap_cond_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  cond = '0;
  logic        use_imm = 1'b0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [15:0] imm = '0;
  logic [31:0] insn_word = '0;
  logic        trap_fire;
  logic [31:0] trap_word;

  int checks = 0, fails = 0;
  logic        exp_fire = 1'b0;
  logic [31:0] exp_word = '0;
  string       cur_tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  trap_cond_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
    .use_imm(use_imm), .src_a(src_a), .src_b(src_b), .imm(imm),
    .insn_word(insn_word), .trap_fire(trap_fire), .trap_word(trap_word));

  function automatic bit model_hit(input logic [2:0] c, input bit ui,
      input logic [63:0] a, input logic [63:0] b, input logic [15:0] im);
    longint sa, sb;
    logic [63:0] bv;
    bv = ui ? {{48{im[15]}}, im} : b;
    sa = a; sb = bv;
    case (c)
      3'd0: return a == bv;
      3'd1: return a != bv;
      3'd2: return sa >= sb;
      3'd3: return a >= bv;
      3'd4: return sa < sb;
      3'd5: return a < bv;
      default: return 0;
    endcase
  endfunction

  task automatic compare;
    checks++;
    if (trap_fire !== exp_fire || trap_word !== exp_word) begin
      fails++;
      $display("FAIL %s: fire=%0b word=%h expected fire=%0b word=%h",
               cur_tag, trap_fire, trap_word, exp_fire, exp_word);
    end
  endtask

  task automatic step(input string tag, input bit v, input logic [2:0] c, input bit ui,
      input logic [63:0] a, input logic [63:0] b, input logic [15:0] im,
      input logic [31:0] w);
    bit h;
    @(negedge clk);
    compare();
    cur_tag = tag;
    in_valid = v; cond = c; use_imm = ui; src_a = a; src_b = b; imm = im; insn_word = w;
    h = v && model_hit(c, ui, a, b, im);
    exp_fire = h;
    if (h) exp_word = w;
  endtask

  initial begin
    #(PERIOD*200000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) begin @(negedge clk); compare(); end   // R1 during reset
    rst_n = 1'b1;
    step("R1", 0, 3'd0, 0, 64'd5, 64'd5, 16'd0, 32'h1);
    step("R2", 1, 3'd0, 0, 64'h1234, 64'h1234, 16'd0, 32'hA0000001);
    step("R2", 1, 3'd0, 0, 64'h8000_0000_0000_1234, 64'h1234, 16'd0, 32'hA0000002);
    step("R2", 1, 3'd1, 0, 64'h8000_0000_0000_1234, 64'h1234, 16'd0, 32'hA0000003);
    step("R2", 1, 3'd1, 0, 64'h77, 64'h77, 16'd0, 32'hA0000004);
    step("R3", 1, 3'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 32'hB0000001);
    step("R3", 1, 3'd4, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 32'hB0000002);
    step("R3", 1, 3'd2, 0, 64'd9, 64'd9, 16'd0, 32'hB0000003);
    step("R3", 1, 3'd4, 0, 64'd9, 64'd9, 16'd0, 32'hB0000004);
    step("R4", 1, 3'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 32'hC0000001);
    step("R4", 1, 3'd5, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 32'hC0000002);
    step("R4", 1, 3'd5, 0, 64'd3, 64'h8000_0000_0000_0000, 16'd0, 32'hC0000003);
    step("R5", 1, 3'd0, 1, 64'hFFFF_FFFF_FFFF_8000, 64'd0, 16'h8000, 32'hD0000001);
    step("R5", 1, 3'd4, 1, 64'd0, 64'd0, 16'hFFFF, 32'hD0000002);
    step("R5", 1, 3'd2, 1, 64'd0, 64'd0, 16'hFFFF, 32'hD0000003);
    step("R6", 1, 3'd3, 1, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 16'hFFFF, 32'hE0000001);
    step("R6", 1, 3'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'hFFFF, 32'hE0000002);
    step("R6", 1, 3'd5, 1, 64'h0000_0000_0001_0000, 64'd0, 16'h8000, 32'hE0000003);
    step("R7", 1, 3'd6, 0, 64'd1, 64'd1, 16'd1, 32'hF0000001);
    step("R7", 1, 3'd7, 1, 64'd1, 64'd0, 16'd1, 32'hF0000002);
    step("R8", 0, 3'd0, 0, 64'd4, 64'd4, 16'd0, 32'h12345678);
    step("R8", 1, 3'd0, 0, 64'd4, 64'd4, 16'd0, 32'h11111111);
    step("R8", 1, 3'd0, 0, 64'd4, 64'd4, 16'd0, 32'h22222222);
    step("R9", 1, 3'd1, 0, 64'd4, 64'd4, 16'd0, 32'h33333333);
    step("R10", 1, 3'd0, 1, 64'd7, 64'd99, 16'd7, 32'h44444444);
    step("R10", 1, 3'd0, 0, 64'd7, 64'd7, 16'd99, 32'h55555555);
    step("R10", 1, 3'd0, 1, 64'd99, 64'd99, 16'd7, 32'h66666666);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      logic [15:0] im;
      a = {$urandom, $urandom};
      b = (i % 5 == 0) ? a : {$urandom, $urandom};
      im = (i % 7 == 0) ? a[15:0] : 16'($urandom);
      if (i % 3 == 0) a = {{48{im[15]}}, im} + 64'($urandom_range(0, 2)) - 64'd1;
      step("R8", ($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
           bit'($urandom_range(0, 1)), a, b, im, $urandom);
    end
    step("R9", 0, 3'd0, 0, 64'd0, 64'd0, 16'd0, 32'h0);
    @(negedge clk); compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule